// File: doc/BRIEF.md
# Receive Destination Address Filter

This block watches the opening bytes of each incoming Ethernet frame and decides whether the frame should be kept. The frame arrives one byte per valid cycle. A start flag marks the first byte and a last flag marks the final byte. The first six bytes form the destination address. While they stream in, the block builds a CRC-32 over them to get a multicast hash index. It also keeps a copy of the address so that it can be compared with the station address.

Three tests are applied in a fixed priority order:
- all-ones broadcast,
- hash lookup, used for group addresses or when the hash-everything mode is on,
- exact station match.

A frame that fails its test is a miss. A miss is dropped unless promiscuous mode is on. In promiscuous mode the frame is kept, and the miss flag goes with it so that a later stage can place it in the receive status word.

The decision is registered one cycle after the sixth byte, or one cycle after the last byte of a shorter frame. It stays on the outputs until the next frame start.

Top module: `daf_top`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_miss` are all 0, and they stay 0 until a frame has been decided.
- R2: `dec_valid` rises in the cycle after the sixth address byte is taken. It is 0 in the cycle after any start byte that is not also a last byte. Once set, the decision holds unchanged until the next start byte.
- R3: A frame whose last byte comes before its sixth byte is a miss. Its decision appears in the cycle after that last byte.
- R4: A destination of all-ones is a miss exactly when `cfg_mode[3]` (reject broadcast) is 1.
- R5: A destination that is not all-ones, and that has bit 0 of its first byte set or has `cfg_mode[4]` (hash everything) at 1, is looked up in the hash table. The details of the lookup are:
  - The index is bits 31:26 of a CRC register that starts at all ones and has no final inversion.
  - The register uses polynomial 0x04C11DB7, shifts toward the MSB and takes each byte LSB first.
  - Index bit 5 picks `cfg_hash_hi` when 1 and `cfg_hash_lo` when 0, and index bits 4:0 pick the bit in that word.
  - A 0 in the selected bit means a miss.
- R6: Any other destination hits only if the first byte through the sixth byte are, in that order, `cfg_station_hi[15:8]`, `cfg_station_hi[7:0]`, `cfg_station_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`.
- R7: `dec_miss` shows the miss result. `dec_accept` is 1 on a hit, or on a miss when `cfg_mode[5]` (promiscuous) is 1.
- R8: Bytes after the sixth byte, and cycles with `in_valid` low inside the address, do not change the decision.
- R9: Broadcast takes priority over the hash lookup, and the hash lookup (when `cfg_mode[4]` is set) takes priority over the exact station match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A frame byte is present |
| in_start | input | 1 | This byte is the first of a frame |
| in_last | input | 1 | This byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| cfg_station_hi | input | 16 | Station address, bytes one and two |
| cfg_station_lo | input | 32 | Station address, bytes three to six |
| cfg_hash_lo | input | 32 | Hash bits for indices 0 to 31 |
| cfg_hash_hi | input | 32 | Hash bits for indices 32 to 63 |
| cfg_mode | input | 3 (bits 5:3) | Bit 3 reject broadcast, bit 4 hash everything, bit 5 promiscuous |
| dec_valid | output | 1 | Decision present for the current frame |
| dec_accept | output | 1 | Frame is to be kept |
| dec_miss | output | 1 | Frame failed its address test |

## Verification
The hardest case to reach from the ports is a single frame that also meets a lower-priority path. Examples are a broadcast with hash-everything on, and the exact station address with hash-everything on where the selected hash bit is clear. Only the priority order decides the result in these cases.

The bench gets there by sweeping all mode combinations over the broadcast address and over the station address. It also sweeps group addresses whose hash bits land on both table words. For each, the bench works out the CRC index itself and predicts the result. Short frames of every length below six, bubbles inside the address, and trailing bytes cover the timing.

// File: rtl/daf_pkg.sv
package daf_pkg;
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = ADDR_BYTES * BYTE_W;
  localparam int CRC_W      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
  localparam logic [CRC_W-1:0] CRC_INIT = '1;
  localparam int HASH_BITS  = 6;
  localparam int WORD_W     = 32;
  localparam int SEL_BITS   = $clog2(WORD_W);

  typedef enum logic [1:0] {PATH_BCAST, PATH_HASH, PATH_UNI} path_e;

  // one byte into the CRC register, data taken LSB first
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    logic fb;
    r = c;
    for (int k = 0; k < BYTE_W; k++) begin
      fb = r[CRC_W-1] ^ d[k];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/daf_crc_hash.sv
module daf_crc_hash
  import daf_pkg::*;
#(
  parameter int IDX_W = HASH_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_valid,
  input  logic              frame_start,
  input  logic [BYTE_W-1:0] byte_data,
  output logic [IDX_W-1:0]  hash_idx
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_base;
  logic [CRC_W-1:0] crc_next;

  always_comb begin
    crc_base = frame_start ? CRC_INIT : crc_q;
    crc_next = crc_byte(crc_base, byte_data);
  end

  // index for the address ending with the current byte
  assign hash_idx = crc_next[CRC_W-1 -: IDX_W];

  always_ff @(posedge clk) begin
    if (rst)             crc_q <= CRC_INIT;
    else if (byte_valid) crc_q <= crc_next;
  end
endmodule

// File: rtl/daf_addr_capture.sv
module daf_addr_capture
  import daf_pkg::*;
#(
  parameter int NBYTES = ADDR_BYTES
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   byte_valid,
  input  logic                   frame_start,
  input  logic                   frame_end,
  input  logic [BYTE_W-1:0]      byte_data,
  output logic [NBYTES*BYTE_W-1:0] dest_addr,
  output logic                   decide_full,
  output logic                   decide_short
);
  localparam int CNT_W = $clog2(NBYTES + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NBYTES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  pos;
  logic              in_addr;
  logic [BYTE_W-1:0] store_q [NBYTES-1];

  assign pos     = frame_start ? '0 : cnt_q;
  assign in_addr = byte_valid && (pos < FULL);

  // count saturates at FULL: idle before any start and after the address
  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= FULL;
    else if (in_addr) cnt_q <= pos + CNT_W'(1);
  end

  for (genvar g = 0; g < NBYTES - 1; g++) begin : g_store
    always_ff @(posedge clk) begin
      if (in_addr && pos == CNT_W'(g)) store_q[g] <= byte_data;
    end
    assign dest_addr[NBYTES*BYTE_W-1-g*BYTE_W -: BYTE_W] = store_q[g];
  end
  assign dest_addr[BYTE_W-1:0] = byte_data;

  assign decide_full  = in_addr && (pos == LAST);
  assign decide_short = in_addr && frame_end && (pos < LAST);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL);
  assert_one_decision_R3: assert property (@(posedge clk) disable iff (rst)
    !(decide_full && decide_short));
endmodule

// File: rtl/daf_match.sv
module daf_match
  import daf_pkg::*;
(
  input  logic [ADDR_W-1:0]    dest_addr,
  input  logic [HASH_BITS-1:0] hash_idx,
  input  logic [15:0]          station_hi,
  input  logic [31:0]          station_lo,
  input  logic [WORD_W-1:0]    hash_lo,
  input  logic [WORD_W-1:0]    hash_hi,
  input  logic                 no_bcast,
  input  logic                 hash_all,
  output path_e                path,
  output logic                 miss
);
  logic [WORD_W-1:0] word;
  logic              hash_hit;

  always_comb begin
    if (&dest_addr)                               path = PATH_BCAST;
    else if (dest_addr[ADDR_W-BYTE_W] || hash_all) path = PATH_HASH;
    else                                          path = PATH_UNI;
  end

  assign word     = hash_idx[HASH_BITS-1] ? hash_hi : hash_lo;
  assign hash_hit = word[hash_idx[SEL_BITS-1:0]];

  always_comb begin
    unique case (path)
      PATH_BCAST: miss = no_bcast;
      PATH_HASH:  miss = !hash_hit;
      default:    miss = (dest_addr != {station_hi, station_lo});
    endcase
  end

  assert_path_prio_R9: assert final ((path != PATH_UNI) ||
    (!dest_addr[ADDR_W-BYTE_W] && !hash_all && !(&dest_addr)));
endmodule

// File: rtl/daf_top.sv
module daf_top
  import daf_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_start,
  input  logic        in_last,
  input  logic [7:0]  in_data,
  input  logic [15:0] cfg_station_hi,
  input  logic [31:0] cfg_station_lo,
  input  logic [31:0] cfg_hash_lo,
  input  logic [31:0] cfg_hash_hi,
  input  logic [5:3]  cfg_mode,
  output logic        dec_valid,
  output logic        dec_accept,
  output logic        dec_miss
);
  logic [ADDR_W-1:0]    dest_addr;
  logic [HASH_BITS-1:0] hash_idx;
  logic                 decide_full;
  logic                 decide_short;
  logic                 match_miss;
  logic                 now_miss;
  path_e                path;

  daf_crc_hash #(.IDX_W(HASH_BITS)) u_crc (
    .clk(clk), .rst(rst), .byte_valid(in_valid), .frame_start(in_start),
    .byte_data(in_data), .hash_idx(hash_idx)
  );

  daf_addr_capture #(.NBYTES(ADDR_BYTES)) u_cap (
    .clk(clk), .rst(rst), .byte_valid(in_valid), .frame_start(in_start),
    .frame_end(in_last), .byte_data(in_data), .dest_addr(dest_addr),
    .decide_full(decide_full), .decide_short(decide_short)
  );

  daf_match u_match (
    .dest_addr(dest_addr), .hash_idx(hash_idx),
    .station_hi(cfg_station_hi), .station_lo(cfg_station_lo),
    .hash_lo(cfg_hash_lo), .hash_hi(cfg_hash_hi),
    .no_bcast(cfg_mode[3]), .hash_all(cfg_mode[4]),
    .path(path), .miss(match_miss)
  );

  assign now_miss = decide_short | match_miss;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_miss   <= 1'b0;
    end else if (decide_full || decide_short) begin
      dec_valid  <= 1'b1;
      dec_miss   <= now_miss;
      dec_accept <= !now_miss || cfg_mode[5];
    end else if (in_valid && in_start) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_miss   <= 1'b0;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!dec_accept && !dec_miss));
  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_start && !in_last) |=> !dec_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !(in_valid && in_start)) |=>
      (dec_valid && $stable(dec_accept) && $stable(dec_miss)));
  assert_hit_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && !dec_miss) |-> dec_accept);
  assert_promisc_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(dec_valid) && dec_miss) |-> (dec_accept == $past(cfg_mode[5])));
  assert_short_miss_R3: assert property (@(posedge clk) disable iff (rst)
    decide_short |=> (dec_valid && dec_miss));
endmodule

// File: tb/test_daf_top.sv
`timescale 1ns/1ps
module test_daf_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, in_start, in_last;
  logic [7:0]  in_data;
  logic [15:0] cfg_station_hi;
  logic [31:0] cfg_station_lo, cfg_hash_lo, cfg_hash_hi;
  logic [5:3]  cfg_mode;
  logic        dec_valid, dec_accept, dec_miss;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  daf_top i_daf_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_start(in_start),
    .in_last(in_last), .in_data(in_data), .cfg_station_hi(cfg_station_hi),
    .cfg_station_lo(cfg_station_lo), .cfg_hash_lo(cfg_hash_lo),
    .cfg_hash_hi(cfg_hash_hi), .cfg_mode(cfg_mode), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_miss(dec_miss)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = '1;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] d = a[47 - 8*b -: 8];
      for (int k = 0; k < 8; k++) begin
        logic fb = c[31] ^ d[k];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c;
  endfunction

  function automatic logic ref_miss(input logic [47:0] a, input int len);
    logic [5:0]  idx;
    logic [31:0] w;
    if (len < 6) return 1'b1;                        // R3
    if (a == '1) return cfg_mode[3];                 // R4, R9
    if (a[40] || cfg_mode[4]) begin                  // R5, R9
      idx = ref_crc(a) >> 26;
      w = idx[5] ? cfg_hash_hi : cfg_hash_lo;
      return !w[idx[4:0]];
    end
    return a != {cfg_station_hi, cfg_station_lo};    // R6
  endfunction

  task automatic idle();
    in_valid = 0; in_start = 0; in_last = 0; in_data = '0;
  endtask

  task automatic run_frame(input logic [47:0] a, input int len, input int gap, input string req);
    logic em, ea;
    em = ref_miss(a, len);
    ea = !em || cfg_mode[5];                         // R7
    for (int i = 0; i < len; i++) begin
      if (i > 0) for (int g = 0; g < gap; g++) begin @(negedge clk); idle(); end
      @(negedge clk);
      if (i == 1) check("R2 clear after start", 32'(dec_valid), 0);
      if (i == 5) check("R2 not early", 32'(dec_valid), 0);
      in_valid = 1;
      in_start = (i == 0);
      in_last  = (i == len - 1);
      in_data  = (i < 6) ? 8'(a >> (8*(5-i))) : 8'(i * 17 + 3);
    end
    @(negedge clk); idle();
    check({req, " valid"}, 32'(dec_valid), 1);
    check({req, " miss"}, 32'(dec_miss), 32'(em));
    check({req, " accept R7"}, 32'(dec_accept), 32'(ea));
    repeat (2) @(negedge clk);
    check("R2 hold", {dec_valid, dec_miss, dec_accept}, {1'b1, em, ea});
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] st, a;
    cfg_station_hi = 16'h0A1B;
    cfg_station_lo = 32'h2C3D4E5F;
    cfg_hash_lo = 32'hA5C30F96;
    cfg_hash_hi = 32'h5A3CF069;
    cfg_mode = 3'b000;
    st = {cfg_station_hi, cfg_station_lo};
    idle();
    rst = 1;
    repeat (3) @(negedge clk);
    check("R1 reset valid", 32'(dec_valid), 0);
    check("R1 reset accept", 32'(dec_accept), 0);
    check("R1 reset miss", 32'(dec_miss), 0);
    rst = 0;
    // stray bytes without a start leave the outputs quiet
    @(negedge clk); in_valid = 1; in_data = 8'hFF;
    @(negedge clk); idle();
    @(negedge clk);
    check("R1 no start no decision", 32'(dec_valid), 0);

    // broadcast across all modes
    for (int m = 0; m < 8; m++) begin
      cfg_mode = 3'(m);
      run_frame('1, 6, 0, "R4 R9 broadcast");
    end
    // station address across all modes: hash-all overrides exact match
    for (int m = 0; m < 8; m++) begin
      cfg_mode = 3'(m);
      run_frame(st, 6, 0, "R6 R9 station");
    end
    // group addresses through the hash table
    for (int i = 0; i < 48; i++) begin
      a = {8'(8'h01 + 8'(i*2)), 8'(i*29 + 3), 8'(i*7), 8'(8'h5A ^ 8'(i)),
           8'(i*i), 8'(i + 100)};
      cfg_mode = {1'(i), 1'b0, 1'(i >> 1)};
      run_frame(a, 6, 0, "R5 group");
    end
    // unicast addresses looked up because hash-all is set
    for (int i = 0; i < 24; i++) begin
      a = {8'(8'h10 + 8'(i*4)), 8'(i*13), 8'h22, 8'(i*5 + 1), 8'h77, 8'(i)};
      cfg_mode = {1'b0, 1'b1, 1'b0};
      run_frame(a, 6, 0, "R5 R9 hash-all");
    end
    // exact match against each single differing byte
    cfg_mode = 3'b000;
    for (int b = 0; b < 6; b++) begin
      a = st ^ (48'h02 << (8*(5-b)));
      run_frame(a, 6, 0, "R6 byte differs");
      cfg_mode = 3'b100;
      run_frame(a, 6, 0, "R6 R7 promiscuous");
      cfg_mode = 3'b000;
    end
    run_frame(st, 6, 0, "R6 exact hit");
    // short frames
    for (int len = 1; len < 6; len++) begin
      cfg_mode = 3'b000;
      run_frame(st, len, 0, "R3 short");
      cfg_mode = 3'b100;
      run_frame(st, len, 1, "R3 short promiscuous");
    end
    // trailing bytes and bubbles
    cfg_mode = 3'b000;
    run_frame(st, 12, 0, "R8 trailing");
    run_frame(st, 9, 3, "R8 bubbles");
    run_frame(st ^ 48'h1, 10, 2, "R8 trailing miss");
    cfg_mode = 3'b010;
    run_frame({8'h33, 40'h0102030405}, 11, 1, "R8 R5 trailing group");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule